// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps the cells of a synchronous DRAM alive. A free-running interval timer adds one owed refresh to a debt counter at each interval expiry. Whenever the debt is non-zero and no refresh sequence is running, the block raises a request toward the controller's command arbiter. The arbiter may let requests wait while traffic is heavy, so owed refreshes pile up. Once the debt reaches its ceiling, an urgent flag tells the arbiter to preempt everything else.

When the arbiter grants, the scheduler takes the command bus. It first closes every bank with a precharge-all command. It then waits out the precharge time and issues one auto-refresh command. It holds the bus until the row cycle time has elapsed. In every other cycle it drives a no-operation. All timing limits are given in nanoseconds and are turned into clock counts from the clock period parameter. The retention interval is rounded down so that refreshes are never late. The precharge time and the row cycle time are rounded up.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the bus shows NOP, `ref_req` and `ref_urgent` are low, `pending` is 0 and `busy` is low.
- R2: One refresh is added to the debt every IVL clocks, where IVL = floor(REFI_NS*1000/CLK_PS) with a minimum of 1. The first addition takes effect on the IVL-th rising edge after reset is released.
- R3: `ref_req` is high exactly when `pending` is non-zero and `busy` is low. In the first idle cycle after a sequence, it is high again if debt remains.
- R4: A grant sampled while `ref_req` is high puts precharge-all on the bus in the next cycle: {cs_n,ras_n,cas_n,we_n} = 0010 with `addr10` high.
- R5: Auto-refresh ({cs_n,ras_n,cas_n,we_n} = 0001, `addr10` low) is driven exactly RP clocks after the precharge-all.
- R6: `busy` is high from the precharge-all cycle to RC-1 cycles after the auto-refresh. It is low RC cycles after the auto-refresh.
- R7: In every cycle that carries neither precharge-all nor auto-refresh, the bus shows NOP = 0111 with `addr10` low.
- R8: `pending` drops by one on the edge that ends the auto-refresh cycle. If an interval expiry lands on that same edge, `pending` stays unchanged.
- R9: `ref_urgent` is high exactly when `pending` equals MAX_DEBT.
- R10: `pending` never exceeds MAX_DEBT. An interval expiry at MAX_DEBT with no refresh issued is lost.
- R11: A grant while `ref_req` is low has no effect: `busy` stays low and the bus stays NOP.
- R12: RP = ceil(TRP_NS*1000/CLK_PS) and RC = ceil(TRC_NS*1000/CLK_PS), each at least 1.

Top module ports are listed in declaration order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Arbiter grant of the command bus |
| ref_req | output | 1 | Refresh is owed and the scheduler is idle |
| ref_urgent | output | 1 | Debt at its ceiling; preempt other traffic |
| pending | output | $clog2(MAX_DEBT+1) | Number of owed refreshes |
| busy | output | 1 | Scheduler owns the command bus |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr10 | output | 1 | Address bit 10; high selects all banks on precharge |

## Verification
The assertions assume that the arbiter treats the grant as a single-cycle pulse tied to a visible request. They also assume that a grant arriving while the request is low is simply discarded, not held until the next request. The bench keeps to these assumptions. It raises the grant only on a falling edge where it has just seen the request high, and drops it one cycle later. The one deliberate exception is a burst of grants during an idle, debt-free window, which checks that such grants are ignored. The bench gives the interval, precharge and row-cycle times small values, so that debt saturation and draining both fit into a few hundred clocks.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RP,
    ST_REF,
    ST_RC
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP    = 4'b0111;
  localparam logic [3:0] CMD_PREALL = 4'b0010;
  localparam logic [3:0] CMD_AREF   = 4'b0001;

  function automatic int ns_to_cyc_ceil(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int ns_to_cyc_floor(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sdram_ref_tick.sv
module sdram_ref_tick #(
  parameter int IVL_CYC = 2080
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (IVL_CYC > 1) ? $clog2(IVL_CYC) : 1;

  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end = (cnt == W'(IVL_CYC - 1));
  assign tick   = at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (at_end) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sdram_ref_debt.sv
module sdram_ref_debt #(
  parameter int MAX_DEBT = 8,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ref_done,
  output logic [CW-1:0] pending,
  output logic          urgent
);
  localparam logic [CW-1:0] CEIL = CW'(MAX_DEBT);

  logic [CW-1:0] nxt;

  always_comb begin
    nxt = pending;
    if (tick && !ref_done) begin
      if (pending != CEIL) nxt = pending + 1'b1;
    end else if (!tick && ref_done) begin
      if (pending != '0) nxt = pending - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= '0;
    else        pending <= nxt;
  end

  assign urgent = (pending == CEIL);
endmodule

// File: rtl/sdram_ref_seq.sv
module sdram_ref_seq
  import sdram_refresh_pkg::*;
#(
  parameter int RP_CYC = 3,
  parameter int RC_CYC = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic [3:0] cmd,
  output logic       a10,
  output logic       busy,
  output logic       ref_done
);
  localparam int MAXC = (RP_CYC > RC_CYC) ? RP_CYC : RC_CYC;
  localparam int WC   = $clog2(MAXC + 1);

  seq_state_e    state;
  logic [WC-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) state <= ST_PRE;
        ST_PRE: begin
          if (RP_CYC <= 1) state <= ST_REF;
          else begin
            state <= ST_RP;
            cnt   <= WC'(RP_CYC - 2);
          end
        end
        ST_RP: begin
          if (cnt == '0) state <= ST_REF;
          else           cnt   <= cnt - 1'b1;
        end
        ST_REF: begin
          if (RC_CYC <= 1) state <= ST_IDLE;
          else begin
            state <= ST_RC;
            cnt   <= WC'(RC_CYC - 2);
          end
        end
        ST_RC: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd = CMD_NOP;
    a10 = 1'b0;
    if (state == ST_PRE) begin
      cmd = CMD_PREALL;
      a10 = 1'b1;
    end else if (state == ST_REF) begin
      cmd = CMD_AREF;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign ref_done = (state == ST_REF);
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_refresh_pkg::*;
#(
  parameter int CLK_PS   = 7500,
  parameter int REFI_NS  = 15600,
  parameter int TRP_NS   = 20,
  parameter int TRC_NS   = 65,
  parameter int MAX_DEBT = 8,
  localparam int CW      = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_gnt,
  output logic          ref_req,
  output logic          ref_urgent,
  output logic [CW-1:0] pending,
  output logic          busy,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          addr10
);
  localparam int IVL_CYC = ns_to_cyc_floor(REFI_NS, CLK_PS);
  localparam int RP_CYC  = ns_to_cyc_ceil(TRP_NS, CLK_PS);
  localparam int RC_CYC  = ns_to_cyc_ceil(TRC_NS, CLK_PS);

  // named internal events
  logic       tick_evt;
  logic       grant_evt;
  logic       aref_evt;
  logic [3:0] cmd;

  sdram_ref_tick #(.IVL_CYC(IVL_CYC)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_evt)
  );

  sdram_ref_debt #(.MAX_DEBT(MAX_DEBT), .CW(CW)) u_debt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_evt),
    .ref_done(aref_evt),
    .pending (pending),
    .urgent  (ref_urgent)
  );

  sdram_ref_seq #(.RP_CYC(RP_CYC), .RC_CYC(RC_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (grant_evt),
    .cmd     (cmd),
    .a10     (addr10),
    .busy    (busy),
    .ref_done(aref_evt)
  );

  assign ref_req   = (pending != '0) && !busy;
  assign grant_evt = ref_req && ref_gnt;
  assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/sdram_refresh_chk.sv
module sdram_refresh_chk
  import sdram_refresh_pkg::*;
#(
  parameter int CLK_PS   = 7500,
  parameter int TRP_NS   = 20,
  parameter int TRC_NS   = 65,
  parameter int MAX_DEBT = 8,
  parameter int CW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic [CW-1:0] pending,
  input logic          busy,
  input logic          cs_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          addr10,
  input logic          tick_evt
);
  localparam int RP_CYC = ns_to_cyc_ceil(TRP_NS, CLK_PS);
  localparam int RC_CYC = ns_to_cyc_ceil(TRC_NS, CLK_PS);

  logic [3:0]  bus;
  logic        is_pre, is_ref, pre_seen;
  logic [15:0] since_pre, since_ref;

  assign bus    = {cs_n, ras_n, cas_n, we_n};
  assign is_pre = (bus == CMD_PREALL);
  assign is_ref = (bus == CMD_AREF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_seen  <= 1'b0;
      since_pre <= '0;
      since_ref <= '0;
    end else begin
      if (is_pre) begin
        pre_seen  <= 1'b1;
        since_pre <= 16'd1;
      end else if (since_pre != 16'hFFFF) since_pre <= since_pre + 1'b1;
      if (is_ref) since_ref <= 16'd1;
      else if (since_ref != 16'hFFFF) since_ref <= since_ref + 1'b1;
    end
  end

  // R7: only the three legal encodings ever appear
  always_comb begin
    if (rst_n) a_r7_legal_cmd: assert (bus == CMD_NOP || is_pre || is_ref);
  end

  a_r3_req_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !busy);

  a_r4_pre_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && ref_req) |=> (is_pre && addr10));

  a_r5_rp_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (pre_seen && since_pre == 16'(RP_CYC)));

  a_r6_rc_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (since_ref == 16'(RC_CYC)));

  a_r8_ref_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && !tick_evt) |=> (pending == CW'($past(pending) - 1'b1)));

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == CW'(MAX_DEBT) && !is_ref) |=> (pending == CW'(MAX_DEBT)));

  a_r11_grant_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && !ref_req && !busy) |=> (!busy && bus == CMD_NOP));
endmodule

bind sdram_refresh_sched sdram_refresh_chk #(
  .CLK_PS  (CLK_PS),
  .TRP_NS  (TRP_NS),
  .TRC_NS  (TRC_NS),
  .MAX_DEBT(MAX_DEBT),
  .CW      (CW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_gnt (ref_gnt),
  .ref_req (ref_req),
  .pending (pending),
  .busy    (busy),
  .cs_n    (cs_n),
  .ras_n   (ras_n),
  .cas_n   (cas_n),
  .we_n    (we_n),
  .addr10  (addr10),
  .tick_evt(tick_evt)
);

// File: tb/sdram_refresh_sched_test.sv
`timescale 1ns/1ps
module sdram_refresh_sched_test;
  // 20 ns clock: interval 400 ns -> 20 clocks, precharge 45 ns -> 3, row cycle 65 ns -> 4
  localparam int IVL  = 20;
  localparam int MAXD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, urg, busy, cs_n, ras_n, cas_n, we_n, a10;
  logic [3:0] pend;

  int checks = 0, fails = 0;
  bit done = 1'b0, mon_en = 1'b0;
  int edges = 0, exp_pend = 0;
  bit ref_seen = 1'b0;

  always #10 clk = ~clk;

  sdram_refresh_sched #(.CLK_PS(20000), .REFI_NS(400), .TRP_NS(45), .TRC_NS(65),
                        .MAX_DEBT(MAXD)) uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req), .ref_urgent(urg),
    .pending(pend), .busy(busy), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr10(a10));

  // expected-sequence table: {cmd[3:0], addr10, busy} per cycle after the grant edge
  localparam logic [5:0] SEQ [8] = '{
    6'b0010_1_1, 6'b0111_0_1, 6'b0111_0_1, 6'b0001_0_1,
    6'b0111_0_1, 6'b0111_0_1, 6'b0111_0_1, 6'b0111_0_0};

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [3:0] busv();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  // debt model from R2/R8/R10
  always @(posedge clk) begin
    if (rst_n) begin
      int t, s;
      edges = edges + 1;
      t = (edges % IVL == 0) ? 1 : 0;
      s = exp_pend + t - (ref_seen ? 1 : 0);
      if (s > MAXD) s = MAXD;
      if (s < 0) s = 0;
      exp_pend = s;
    end
  end

  always @(negedge clk) begin
    ref_seen = rst_n && (busv() == 4'b0001);
    if (mon_en) begin
      chk("R8 pending", int'(pend), exp_pend);
      chk("R9 urgent", int'(urg), (exp_pend == MAXD) ? 1 : 0);
      chk("R3 request", int'(req), (exp_pend != 0 && !busy) ? 1 : 0);
    end
  end

  task automatic run_seq(input string tag);
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk({tag, " R4/R5/R7 cmd"}, int'(busv()), int'(SEQ[i][5:2]));
      chk({tag, " R4/R5 addr10"}, int'(a10), int'(SEQ[i][1]));
      chk({tag, " R6 busy"}, int'(busy), int'(SEQ[i][0]));
      if (i < 7) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 bus", int'(busv()), 4'b0111);
    chk("R1 req", int'(req), 0);
    chk("R1 pending", int'(pend), 0);
    chk("R1 busy", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle busy", int'(busy), 0);
    mon_en = 1'b1;
    // R2: first expiry on edge IVL
    repeat (IVL - 2) @(negedge clk);
    chk("R2 before interval", int'(pend), 0);
    @(negedge clk);
    chk("R2 at interval", int'(pend), 1);
    chk("R2 req", int'(req), 1);
    // R4..R7, R12: full sequence with RP=3, RC=4
    run_seq("seq1");
    // R11: grants while no debt
    gnt = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R11 busy stays low", int'(busy), 0);
      chk("R11 bus NOP", int'(busv()), 4'b0111);
    end
    gnt = 1'b0;
    // R9: debt to seven, then to the ceiling
    while (exp_pend < 7) @(negedge clk);
    chk("R9 not urgent at 7", int'(urg), 0);
    while (exp_pend < MAXD) @(negedge clk);
    chk("R9 urgent at max", int'(urg), 1);
    // R10: saturation
    repeat (2 * IVL + 3) @(negedge clk);
    chk("R10 saturated", int'(pend), MAXD);
    // drain with back-to-back grants
    for (int k = 0; k < 4; k++) begin
      chk("R3 req after sequence", int'(req), 1);
      run_seq("drain");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule